// File: doc/BRIEF.md
# Parseval Energy Checker for a Transform Frame

This block watches one N-point discrete Fourier transform from the outside and flags a frame whose result is inconsistent. It receives two streams: the complex time-domain samples that went into the transform, and the complex frequency-domain bins that came out. Each stream has its own valid and end-of-frame strobes. The block sums the energy (real squared plus imaginary squared) of every accepted sample on each side. It multiplies the input total by N and compares that against the output total. When the frame closes, it pulses a done strobe and reports whether the two totals differ by more than a tolerance.

The check only detects an error. It gives no hint of which bin is bad, so locating and repairing the error belongs to the surrounding logic, for example a parity transform. A fault inside the checker can raise a false flag. The only cost of that is a needless recomputation. The tolerance input absorbs the rounding a fixed-point transform introduces.

Control is a four-state machine:
- IDLE: both totals are zero and no sample has been seen.
- ACCUM: samples are being summed.
- IN_CLOSED: the input stream has delivered its last sample, and further input samples are dropped.
- REPORT: done is high.

Transitions:
- An accepted output sample marked last moves any state to REPORT.
- Otherwise, an accepted input sample marked last moves IDLE, ACCUM or REPORT to IN_CLOSED.
- Otherwise, any accepted sample moves IDLE, ACCUM or REPORT to ACCUM.
- REPORT with no traffic falls back to IDLE.
- IN_CLOSED holds until the frame closes.

Top module: `parseval_check`

## Requirements
- R1: The energy of a sample is re*re + im*im, with re and im read as signed two's complement. This applies to both streams.
- R2: The input energy total is multiplied by N_PTS before the comparison.
- R3: err is 1 exactly when |N_PTS*input_total - output_total| is greater than tol. A difference equal to tol passes.
- R4: done is high for one cycle, in the cycle after an accepted output sample with out_last=1. err can be high only together with done.
- R5: A sample presented while its valid is low has no effect on either total.
- R6: After an accepted input sample with in_last=1, further input samples are ignored until the frame closes.
- R7: Both totals clear when the frame closes. A sample accepted in the cycle done is high starts the next frame.
- R8: A frame of N_PTS samples of the most negative value on both parts cannot overflow either total.
- R9: While reset is held and after it is released, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tol | input | TOL_W | Largest energy difference still treated as a pass |
| in_valid | input | 1 | Time-domain sample present |
| in_last | input | 1 | Last time-domain sample of the frame |
| in_re | input | IN_W | Time-domain real part, signed |
| in_im | input | IN_W | Time-domain imaginary part, signed |
| out_valid | input | 1 | Frequency-domain bin present |
| out_last | input | 1 | Last bin of the frame; closes the frame |
| out_re | input | OUT_W | Bin real part, signed |
| out_im | input | OUT_W | Bin imaginary part, signed |
| done | output | 1 | One-cycle frame-complete strobe |
| err | output | 1 | Energy mismatch, valid while done is high |

## Verification
The bench builds the checker with N_PTS=4, IN_W=4, OUT_W=8 and TOL_W=8. At four points every twiddle is one of ±1 or ±j, so the bench computes the transform exactly in integers and Parseval's relation holds with no rounding. The 4-bit inputs make it feasible to sweep every real/imaginary value of an impulse and every tolerance around the mismatch boundary. The 8-bit outputs can still carry a full frame of most-negative values to exercise the overflow case.

// File: rtl/parseval_pkg.sv
package parseval_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACCUM     = 2'd1,
        ST_IN_CLOSED = 2'd2,
        ST_REPORT    = 2'd3
    } chk_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cplx_energy.sv
module cplx_energy #(
    parameter int W = 16
) (
    input  logic signed [W-1:0]   re,
    input  logic signed [W-1:0]   im,
    output logic        [2*W-1:0] energy
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] re_x;
    logic signed [PW-1:0] im_x;
    logic signed [PW-1:0] re_sq;
    logic signed [PW-1:0] im_sq;

    // Sign-extend before squaring so the product is taken at full width.
    assign re_x  = PW'(re);
    assign im_x  = PW'(im);
    assign re_sq = re_x * re_x;
    assign im_sq = im_x * im_x;

    // Each square is at most 2^(2W-2); their sum fits in 2W unsigned bits.
    assign energy = $unsigned(re_sq) + $unsigned(im_sq);

endmodule

// File: rtl/energy_acc.sv
module energy_acc #(
    parameter int E_W = 32,
    parameter int A_W = 35
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           add,
    input  logic           clr,
    input  logic [E_W-1:0] energy,
    output logic [A_W-1:0] total_nxt,
    output logic [A_W-1:0] total_q
);
    logic [A_W-1:0] term;

    assign term      = add ? A_W'(energy) : '0;
    assign total_nxt = total_q + term;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clr) begin
            total_q <= '0;
        end else begin
            total_q <= total_nxt;
        end
    end

endmodule

// File: rtl/energy_cmp.sv
module energy_cmp #(
    parameter int N_PTS    = 8,
    parameter int IN_A_W   = 35,
    parameter int OUT_A_W  = 43,
    parameter int TOL_W    = 16,
    parameter int CMP_W    = 44
) (
    input  logic [IN_A_W-1:0]  in_total,
    input  logic [OUT_A_W-1:0] out_total,
    input  logic [TOL_W-1:0]   tol,
    output logic               mismatch
);
    localparam int SH = $clog2(N_PTS);

    logic [CMP_W-1:0] scaled;
    logic [CMP_W-1:0] out_ext;
    logic [CMP_W-1:0] tol_ext;
    logic [CMP_W-1:0] diff;

    // A power-of-two length scales by a shift; any other length uses a constant multiply.
    generate
        if ((N_PTS & (N_PTS - 1)) == 0) begin : g_shift
            assign scaled = CMP_W'(in_total) << SH;
        end else begin : g_mult
            assign scaled = CMP_W'(in_total) * CMP_W'(N_PTS);
        end
    endgenerate

    assign out_ext  = CMP_W'(out_total);
    assign tol_ext  = CMP_W'(tol);
    assign diff     = (scaled >= out_ext) ? (scaled - out_ext) : (out_ext - scaled);
    assign mismatch = (diff > tol_ext);

endmodule

// File: rtl/parseval_check.sv
module parseval_check
    import parseval_pkg::*;
#(
    parameter int N_PTS = 8,
    parameter int IN_W  = 16,
    parameter int OUT_W = 20,
    parameter int TOL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TOL_W-1:0]        tol,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic signed [IN_W-1:0]  in_re,
    input  logic signed [IN_W-1:0]  in_im,
    input  logic                    out_valid,
    input  logic                    out_last,
    input  logic signed [OUT_W-1:0] out_re,
    input  logic signed [OUT_W-1:0] out_im,
    output logic                    done,
    output logic                    err
);
    localparam int SH        = $clog2(N_PTS);
    localparam int E_IN_W    = 2 * IN_W;
    localparam int E_OUT_W   = 2 * OUT_W;
    localparam int ACC_IN_W  = E_IN_W + SH;
    localparam int ACC_OUT_W = E_OUT_W + SH;
    localparam int CMP_W     = max3(ACC_IN_W + SH, ACC_OUT_W, TOL_W) + 1;

    chk_state_t state_q;
    chk_state_t state_d;

    logic                 in_take;
    logic                 out_take;
    logic                 closing;
    logic                 mismatch;
    logic                 err_q;
    logic [E_IN_W-1:0]    e_in;
    logic [E_OUT_W-1:0]   e_out;
    logic [ACC_IN_W-1:0]  in_total_nxt;
    logic [ACC_IN_W-1:0]  in_total_q;
    logic [ACC_OUT_W-1:0] out_total_nxt;
    logic [ACC_OUT_W-1:0] out_total_q;

    // Input samples are dropped once the input side of the frame has ended.
    assign in_take  = in_valid && (state_q != ST_IN_CLOSED);
    assign out_take = out_valid;
    assign closing  = out_take && out_last;

    cplx_energy #(.W(IN_W)) u_e_in (
        .re     (in_re),
        .im     (in_im),
        .energy (e_in)
    );

    cplx_energy #(.W(OUT_W)) u_e_out (
        .re     (out_re),
        .im     (out_im),
        .energy (e_out)
    );

    energy_acc #(.E_W(E_IN_W), .A_W(ACC_IN_W)) u_acc_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .add       (in_take),
        .clr       (closing),
        .energy    (e_in),
        .total_nxt (in_total_nxt),
        .total_q   (in_total_q)
    );

    energy_acc #(.E_W(E_OUT_W), .A_W(ACC_OUT_W)) u_acc_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .add       (out_take),
        .clr       (closing),
        .energy    (e_out),
        .total_nxt (out_total_nxt),
        .total_q   (out_total_q)
    );

    // Compare the totals including this cycle's samples, so the verdict registers at the closing edge.
    energy_cmp #(
        .N_PTS   (N_PTS),
        .IN_A_W  (ACC_IN_W),
        .OUT_A_W (ACC_OUT_W),
        .TOL_W   (TOL_W),
        .CMP_W   (CMP_W)
    ) u_cmp (
        .in_total  (in_total_nxt),
        .out_total (out_total_nxt),
        .tol       (tol),
        .mismatch  (mismatch)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (closing) begin
                    state_d = ST_REPORT;
                end else if (in_take && in_last) begin
                    state_d = ST_IN_CLOSED;
                end else if (in_take || out_take) begin
                    state_d = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (closing) begin
                    state_d = ST_REPORT;
                end else if (in_take && in_last) begin
                    state_d = ST_IN_CLOSED;
                end
            end
            ST_IN_CLOSED: begin
                if (closing) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                if (closing) begin
                    state_d = ST_REPORT;
                end else if (in_take && in_last) begin
                    state_d = ST_IN_CLOSED;
                end else if (in_take || out_take) begin
                    state_d = ST_ACCUM;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= closing && mismatch;
        end
    end

    assign done = (state_q == ST_REPORT);
    assign err  = err_q;

endmodule

// File: rtl/parseval_check_sva.sv
module parseval_check_sva #(
    parameter int ACC_IN_W  = 35,
    parameter int ACC_OUT_W = 43
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic                 out_last,
    input logic                 in_closed,
    input logic                 done,
    input logic                 err,
    input logic [ACC_IN_W-1:0]  in_total,
    input logic [ACC_OUT_W-1:0] out_total
);
    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_last));

    // R4
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R5
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !(out_valid && out_last)) |=> $stable(in_total));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> $stable(out_total));

    // R6
    closed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_closed && !(out_valid && out_last)) |=> $stable(in_total));

    // R7
    clear_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (in_total == '0 && out_total == '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_closed && !(out_valid && out_last)) |=> (in_total >= $past(in_total)));

    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!err) else $error("err high during reset");
        end
    end

endmodule

bind parseval_check parseval_check_sva #(
    .ACC_IN_W  (ACC_IN_W),
    .ACC_OUT_W (ACC_OUT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_last  (out_last),
    .in_closed (state_q == ST_IN_CLOSED),
    .done      (done),
    .err       (err),
    .in_total  (in_total_q),
    .out_total (out_total_q)
);

// File: tb/sim_parseval_check.sv
module sim_parseval_check;
    localparam int NP    = 4;
    localparam int IN_W  = 4;
    localparam int OUT_W = 8;
    localparam int TOL_W = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [TOL_W-1:0]        tol = '0;
    logic                    in_valid = 1'b0;
    logic                    in_last = 1'b0;
    logic signed [IN_W-1:0]  in_re = '0;
    logic signed [IN_W-1:0]  in_im = '0;
    logic                    out_valid = 1'b0;
    logic                    out_last = 1'b0;
    logic signed [OUT_W-1:0] out_re = '0;
    logic signed [OUT_W-1:0] out_im = '0;
    logic                    done;
    logic                    err;

    parseval_check #(.N_PTS(NP), .IN_W(IN_W), .OUT_W(OUT_W), .TOL_W(TOL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tol(tol),
        .in_valid(in_valid), .in_last(in_last), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_last(out_last), .out_re(out_re), .out_im(out_im),
        .done(done), .err(err)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    pend = 1'b0;
    bit    pend_err = 1'b0;
    string pend_req = "";
    bit    finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int xr[NP];
    int xi[NP];
    int yr[NP];
    int yi[NP];

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Exact 4-point DFT: twiddle W^m with W = -j.
    task automatic do_dft();
        for (int k = 0; k < NP; k++) begin
            int sr = 0;
            int si = 0;
            for (int n = 0; n < NP; n++) begin
                case ((n * k) % 4)
                    0: begin sr += xr[n]; si += xi[n]; end
                    1: begin sr += xi[n]; si -= xr[n]; end
                    2: begin sr -= xr[n]; si -= xi[n]; end
                    default: begin sr -= xi[n]; si += xr[n]; end
                endcase
            end
            yr[k] = sr;
            yi[k] = si;
        end
    endtask

    function automatic longint energy_diff();
        longint ein = 0;
        longint eout = 0;
        longint d;
        for (int n = 0; n < NP; n++) begin
            ein  += longint'(xr[n]) * xr[n] + longint'(xi[n]) * xi[n];
            eout += longint'(yr[n]) * yr[n] + longint'(yi[n]) * yi[n];
        end
        d = NP * ein - eout;
        return (d < 0) ? -d : d;
    endfunction

    task automatic tick();
        @(negedge clk);
        if (pend) begin
            n_checks++;
            if (done !== 1'b1 || err !== pend_err) begin
                n_errors++;
                $display("FAIL %s: done/err actual=%b/%b expected=1/%b", pend_req, done, err, pend_err);
            end
        end else if (done !== 1'b0 || err !== 1'b0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R4: done/err actual=%b/%b expected=0/0 outside report cycle", done, err);
        end
        pend      = 1'b0;
        in_valid  = 1'b0;
        in_last   = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
    endtask

    task automatic drive_in(input int i);
        in_valid = 1'b1;
        in_last  = (i == NP - 1);
        in_re    = IN_W'(xr[i]);
        in_im    = IN_W'(xi[i]);
    endtask

    task automatic drive_out(input int i);
        out_valid = 1'b1;
        out_last  = (i == NP - 1);
        out_re    = OUT_W'(yr[i]);
        out_im    = OUT_W'(yi[i]);
    endtask

    // mode 0: plain, 1: valid gaps with junk data, 2: extra input after in_last, 3: both streams in the same cycles
    task automatic run_frame(input int mode, input int tol_v, input string req);
        bit exp;
        exp = (energy_diff() > longint'(tol_v));
        if (mode == 3) begin
            for (int i = 0; i < NP; i++) begin
                tick();
                if (i == 0) tol = TOL_W'(tol_v);
                drive_in(i);
                drive_out(i);
            end
        end else begin
            for (int i = 0; i < NP; i++) begin
                tick();
                if (i == 0) tol = TOL_W'(tol_v);
                if (mode == 1 && i > 0) begin
                    in_re = 4'sd7; in_im = -4'sd8;
                    tick();
                end
                drive_in(i);
            end
            if (mode == 2) begin
                tick();
                in_valid = 1'b1; in_last = 1'b1; in_re = 4'sd7; in_im = -4'sd8;
            end
            for (int i = 0; i < NP; i++) begin
                tick();
                if (mode == 1 && i > 0) begin
                    out_re = 8'sd127; out_im = -8'sd128;
                    tick();
                end
                drive_out(i);
            end
        end
        pend     = 1'b1;
        pend_err = exp;
        pend_req = req;
    endtask

    task automatic rand_x();
        for (int n = 0; n < NP; n++) begin
            xr[n] = int'(rnd() % 16) - 8;
            xi[n] = int'(rnd() % 16) - 8;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: quiet during and after reset
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (done !== 1'b0 || err !== 1'b0) begin
            n_errors++;
            $display("FAIL R9: done/err actual=%b/%b expected=0/0 in reset", done, err);
        end
        rst_n = 1'b1;
        tick();
        tick();

        // R1/R2: every impulse value; all four bins equal the impulse
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                for (int n = 0; n < NP; n++) begin xr[n] = 0; xi[n] = 0; end
                xr[0] = a; xi[0] = b;
                do_dft();
                run_frame(0, 0, "R1 impulse");
            end
        end

        // R3: tolerance boundary, one bin nudged by +1
        for (int a = -8; a < 8; a++) begin
            int d;
            for (int n = 0; n < NP; n++) begin xr[n] = 0; xi[n] = 0; end
            xr[0] = a; xi[0] = 3;
            do_dft();
            yr[2] = yr[2] + 1;
            d = int'(energy_diff());
            run_frame(0, d, "R3 diff equal to tol");
            if (d > 0) run_frame(0, d - 1, "R3 diff above tol");
        end

        // R1/R2/R3: random frames, some corrupted, back to back (R7)
        for (int f = 0; f < 300; f++) begin
            rand_x();
            do_dft();
            if (rnd() % 2 == 1) begin
                int k = int'(rnd() % NP);
                yr[k] = yr[k] + int'(rnd() % 7) - 3;
                yi[k] = yi[k] + int'(rnd() % 7) - 3;
            end
            run_frame(int'(rnd() % 4), int'(rnd() % 24), "R2 random frame");
        end

        // R5: junk on idle valids
        for (int f = 0; f < 8; f++) begin
            rand_x(); do_dft();
            run_frame(1, 0, "R5 gaps");
        end

        // R6: extra input after in_last
        for (int f = 0; f < 8; f++) begin
            rand_x(); do_dft();
            run_frame(2, 0, "R6 ignored input");
        end

        // R7: corrupted frame followed at once by a clean one
        rand_x(); do_dft(); yr[1] = yr[1] + 5;
        run_frame(0, 0, "R7 first frame");
        rand_x(); do_dft();
        run_frame(0, 0, "R7 second frame clean");
        rand_x(); do_dft(); yi[3] = yi[3] - 4;
        run_frame(3, 0, "R7 overlapped corrupted");
        rand_x(); do_dft();
        run_frame(3, 0, "R7 overlapped clean");

        // R8: extreme magnitudes
        for (int n = 0; n < NP; n++) begin xr[n] = -8; xi[n] = -8; end
        do_dft();
        run_frame(0, 0, "R8 full-scale input");
        for (int n = 0; n < NP; n++) begin xr[n] = 0; xi[n] = 0; yr[n] = -128; yi[n] = -128; end
        run_frame(0, 255, "R8 full-scale output");
        tick();
        tick();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule